// File: doc/BRIEF.md
# Free-Hole Table Allocator

This block keeps a small table of free memory regions ("holes"), each described by a start address and a length. It hands out contiguous regions on request. An allocation request carries a size and a placement policy, and the block walks its table one entry per clock. The policy decides which hole is used: the first one that is big enough, the tightest one that fits, or the biggest one. The block returns the base address of the granted region and shrinks the chosen hole by the granted amount. If no single hole can hold the request, it raises a failure indication instead.

Every request is first rounded up to a whole number of minimum-size partitions, so a grant can be larger than what was asked. A separate release port puts a region back into the table by writing it into the lowest empty slot, and a running total of free space is always visible. Neighbouring holes are never merged, so space can be split into pieces that are too small for a request even when their sum would be enough.

Top module: `hole_alloc`

## Requirements
- R1: After reset the table holds no holes, total_free is 0, req_ready is 1, and done and overflow are 0.
- R2: A release with nonzero free_len is written into the lowest-index empty table slot, and total_free grows by free_len on the next cycle. A release with free_len equal to 0 changes nothing and raises no overflow.
- R3: A nonzero release while every slot is occupied pulses overflow for one cycle and leaves the table and total_free unchanged.
- R4: The granted length is the smallest multiple of 2**MIN_LOG2 that is at least req_size. A req_size of 0 is treated as one minimum partition. The granted length appears on grant_len.
- R5: Policy code 2'b00 (and the spare code 2'b11) selects first-fit: the lowest-index valid hole whose length is at least the rounded size.
- R6: Policy code 2'b01 selects best-fit: the fitting hole with the smallest length.
- R7: Policy code 2'b10 selects worst-fit: the fitting hole with the largest length.
- R8: Under every policy, equal candidate lengths are resolved towards the lowest table index.
- R9: After a grant, the chosen hole keeps its remainder: its base advances by the granted length, its length drops by the same amount, and total_free drops by the granted length.
- R10: A hole whose remainder reaches zero is marked empty, is never offered again, and its slot is reused by a later release.
- R11: When no single hole fits the rounded size, the request ends with fail, even if total_free is large enough, and the table stays unchanged.
- R12: A request is taken when req_valid and req_ready are both high. req_ready is then low until the scan ends. done pulses for exactly one cycle with exactly one of grant_ok or fail. For a first-fit hit at index k, done appears k+1 cycles after acceptance; in every other case it appears NUM_HOLES cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_size | input | LEN_W | Requested length |
| req_policy | input | 2 | Placement policy: 00 first, 01 best, 10 worst, 11 first |
| done | output | 1 | One-cycle pulse when a request completes |
| grant_ok | output | 1 | With done: a region was granted |
| fail | output | 1 | With done: no hole was large enough |
| grant_base | output | ADDR_W | Base address of the granted region (0 on fail) |
| grant_len | output | LEN_W+1 | Rounded length of the request |
| free_valid | input | 1 | Release a region into the table |
| free_base | input | ADDR_W | Start address of the released region |
| free_len | input | LEN_W | Length of the released region |
| overflow | output | 1 | One-cycle pulse: release dropped, table full |
| total_free | output | LEN_W+IDX_W+1 | Sum of all hole lengths in the table |

## Verification
A wrong table entry stays hidden until a later scan reaches it. It then shows up as a wrong grant_base, a different hole being chosen, or a fail where a grant was due. So the bench tracks every hole in its own model and predicts base, length, outcome and done latency for each request. A slip in the running total appears on total_free the cycle after the grant or release that caused it. A bad scan pointer or stop condition moves done away from the index-dependent cycle that each request predicts.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    typedef enum logic [1:0] {
        POL_FIRST     = 2'b00,
        POL_BEST      = 2'b01,
        POL_WORST     = 2'b10,
        POL_FIRST_ALT = 2'b11
    } policy_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

endpackage

// File: rtl/part_round.sv
module part_round #(
    parameter int LEN_W    = 16,
    parameter int MIN_LOG2 = 2
) (
    input  logic [LEN_W-1:0] size_i,
    output logic [LEN_W:0]   rnd_o
);
    localparam int          RW    = LEN_W + 1;
    localparam logic [RW-1:0] MIN_V = RW'(1) << MIN_LOG2;

    logic [RW-1:0] sum;

    always_comb begin
        sum = {1'b0, size_i} + (MIN_V - RW'(1));
        if (size_i == '0) begin
            rnd_o = MIN_V;
        end else begin
            rnd_o = (sum >> MIN_LOG2) << MIN_LOG2;
        end
    end
endmodule

// File: rtl/fit_step.sv
module fit_step
    import alloc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  policy_e          policy_i,
    input  logic [LEN_W:0]   need_i,
    input  logic             ent_valid_i,
    input  logic [LEN_W-1:0] ent_len_i,
    input  logic             run_found_i,
    input  logic [LEN_W-1:0] run_len_i,
    output logic             take_o,
    output logic             stop_o
);
    logic fits;

    always_comb begin
        fits   = ent_valid_i && ({1'b0, ent_len_i} >= need_i);
        take_o = 1'b0;
        stop_o = 1'b0;
        unique case (policy_i)
            POL_BEST: begin
                take_o = fits && (!run_found_i || (ent_len_i < run_len_i));
            end
            POL_WORST: begin
                take_o = fits && (!run_found_i || (ent_len_i > run_len_i));
            end
            default: begin
                take_o = fits && !run_found_i;
                stop_o = take_o;
            end
        endcase
    end
endmodule

// File: rtl/slot_find.sv
module slot_find #(
    parameter int NUM_HOLES = 8,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_HOLES-1:0] valid_i,
    output logic                 any_empty_o,
    output logic [IDX_W-1:0]     empty_idx_o
);
    logic [NUM_HOLES:0]   all_below;
    logic [NUM_HOLES-1:0] first_oh;

    assign all_below[0] = 1'b1;

    for (genvar g = 0; g < NUM_HOLES; g++) begin : g_chain
        assign all_below[g+1] = all_below[g] & valid_i[g];
        assign first_oh[g]    = all_below[g] & ~valid_i[g];
    end

    assign any_empty_o = ~all_below[NUM_HOLES];

    always_comb begin
        empty_idx_o = '0;
        for (int i = 0; i < NUM_HOLES; i++) begin
            if (first_oh[i]) begin
                empty_idx_o = empty_idx_o | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/hole_alloc.sv
module hole_alloc
    import alloc_pkg::*;
#(
    parameter int NUM_HOLES = 8,
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int MIN_LOG2  = 2,
    parameter int IDX_W     = $clog2(NUM_HOLES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [LEN_W-1:0]         req_size,
    input  logic [1:0]               req_policy,
    output logic                     done,
    output logic                     grant_ok,
    output logic                     fail,
    output logic [ADDR_W-1:0]        grant_base,
    output logic [LEN_W:0]           grant_len,
    input  logic                     free_valid,
    input  logic [ADDR_W-1:0]        free_base,
    input  logic [LEN_W-1:0]         free_len,
    output logic                     overflow,
    output logic [LEN_W+IDX_W:0]     total_free
);
    localparam int               RLEN_W = LEN_W + 1;
    localparam int               TOT_W  = LEN_W + IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(NUM_HOLES - 1);

    typedef struct packed {
        scan_st_e              st;
        logic [IDX_W-1:0]      idx;
        policy_e               pol;
        logic [RLEN_W-1:0]     need;
        logic                  found;
        logic [IDX_W-1:0]      bidx;
        logic [LEN_W-1:0]      blen;
        logic                  done;
        logic                  ok;
        logic [ADDR_W-1:0]     gbase;
        logic [RLEN_W-1:0]     glen;
        logic                  ovf;
        logic [TOT_W-1:0]      total;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [ADDR_W-1:0]    base_d [NUM_HOLES];
    logic [ADDR_W-1:0]    base_q [NUM_HOLES];
    logic [LEN_W-1:0]     len_d  [NUM_HOLES];
    logic [LEN_W-1:0]     len_q  [NUM_HOLES];
    logic [NUM_HOLES-1:0] valid_d, valid_q;

    logic [RLEN_W-1:0] req_rnd;
    logic              ent_valid;
    logic [LEN_W-1:0]  ent_len;
    logic              take, ff_stop;
    logic              any_empty;
    logic [IDX_W-1:0]  empty_idx;
    logic              last_step;
    logic              win_found;
    logic [IDX_W-1:0]  win_idx;
    logic [LEN_W-1:0]  win_rem;
    logic [TOT_W-1:0]  tot_add, tot_sub;

    part_round #(.LEN_W(LEN_W), .MIN_LOG2(MIN_LOG2)) u_round (
        .size_i (req_size),
        .rnd_o  (req_rnd)
    );

    assign ent_valid = valid_q[c_q.idx];
    assign ent_len   = len_q[c_q.idx];

    fit_step #(.LEN_W(LEN_W)) u_step (
        .policy_i    (c_q.pol),
        .need_i      (c_q.need),
        .ent_valid_i (ent_valid),
        .ent_len_i   (ent_len),
        .run_found_i (c_q.found),
        .run_len_i   (c_q.blen),
        .take_o      (take),
        .stop_o      (ff_stop)
    );

    slot_find #(.NUM_HOLES(NUM_HOLES), .IDX_W(IDX_W)) u_slot (
        .valid_i     (valid_q),
        .any_empty_o (any_empty),
        .empty_idx_o (empty_idx)
    );

    always_comb begin
        c_d     = c_q;
        base_d  = base_q;
        len_d   = len_q;
        valid_d = valid_q;
        c_d.done = 1'b0;
        c_d.ok   = 1'b0;
        c_d.ovf  = 1'b0;
        tot_add  = '0;
        tot_sub  = '0;

        last_step = (c_q.idx == LAST) || ff_stop;
        win_found = take || c_q.found;
        win_idx   = take ? c_q.idx : c_q.bidx;
        win_rem   = len_q[win_idx] - LEN_W'(c_q.need);

        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.st    = ST_SCAN;
                    c_d.idx   = '0;
                    c_d.pol   = policy_e'(req_policy);
                    c_d.need  = req_rnd;
                    c_d.found = 1'b0;
                    c_d.bidx  = '0;
                    c_d.blen  = '0;
                end
            end
            default: begin
                if (take) begin
                    c_d.found = 1'b1;
                    c_d.bidx  = c_q.idx;
                    c_d.blen  = ent_len;
                end
                if (last_step) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    c_d.glen = c_q.need;
                    if (win_found) begin
                        c_d.ok            = 1'b1;
                        c_d.gbase         = base_q[win_idx];
                        base_d[win_idx]   = base_q[win_idx] + ADDR_W'(c_q.need);
                        len_d[win_idx]    = win_rem;
                        if (win_rem == '0) begin
                            valid_d[win_idx] = 1'b0;
                        end
                        tot_sub = TOT_W'(c_q.need);
                    end else begin
                        c_d.gbase = '0;
                    end
                end else begin
                    c_d.idx = c_q.idx + IDX_W'(1);
                end
            end
        endcase

        if (free_valid && (free_len != '0)) begin
            if (any_empty) begin
                base_d[empty_idx]  = free_base;
                len_d[empty_idx]   = free_len;
                valid_d[empty_idx] = 1'b1;
                tot_add            = TOT_W'(free_len);
            end else begin
                c_d.ovf = 1'b1;
            end
        end

        c_d.total = c_q.total + tot_add - tot_sub;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_IDLE;
            c_q.idx   <= '0;
            c_q.pol   <= POL_FIRST;
            c_q.need  <= '0;
            c_q.found <= 1'b0;
            c_q.bidx  <= '0;
            c_q.blen  <= '0;
            c_q.done  <= 1'b0;
            c_q.ok    <= 1'b0;
            c_q.gbase <= '0;
            c_q.glen  <= '0;
            c_q.ovf   <= 1'b0;
            c_q.total <= '0;
            valid_q   <= '0;
            for (int i = 0; i < NUM_HOLES; i++) begin
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else begin
            c_q     <= c_d;
            valid_q <= valid_d;
            for (int i = 0; i < NUM_HOLES; i++) begin
                base_q[i] <= base_d[i];
                len_q[i]  <= len_d[i];
            end
        end
    end

    assign req_ready  = (c_q.st == ST_IDLE);
    assign done       = c_q.done;
    assign grant_ok   = c_q.done & c_q.ok;
    assign fail       = c_q.done & ~c_q.ok;
    assign grant_base = c_q.gbase;
    assign grant_len  = c_q.glen;
    assign overflow   = c_q.ovf;
    assign total_free = c_q.total;
endmodule

// File: rtl/alloc_chk.sv
module alloc_chk #(
    parameter int NUM_HOLES = 8,
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 16,
    parameter int MIN_LOG2  = 2,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [LEN_W-1:0]     req_size,
    input logic                 done,
    input logic                 grant_ok,
    input logic                 fail,
    input logic [LEN_W:0]       grant_len,
    input logic                 free_valid,
    input logic                 overflow,
    input logic [LEN_W+IDX_W:0] total_free
);
    localparam int TOT_W = LEN_W + IDX_W + 1;
    localparam int MIN_V = 1 << MIN_LOG2;

    logic [LEN_W-1:0] size_cap;
    logic [IDX_W:0]   busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_cap <= '0;
            busy_cnt <= '0;
        end else begin
            if (req_valid && req_ready) size_cap <= req_size;
            if (req_ready) busy_cnt <= '0;
            else           busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R12: no second request while a scan runs
    a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R12: exactly one outcome flag with done, none without
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done ? (grant_ok ^ fail) : (!grant_ok && !fail));

    // R12: done is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: a scan never runs longer than the table
    a_r12_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (int'(busy_cnt) <= NUM_HOLES - 1));

    // R4: grant length is the request rounded up to the partition size
    a_r4_grant_rounded: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((size_cap == '0) ? (int'(grant_len) == MIN_V)
                 : ((int'(grant_len) >= int'(size_cap)) &&
                    (int'(grant_len) - int'(size_cap) < MIN_V) &&
                    (int'(grant_len) % MIN_V == 0))));

    // R9: total free space falls by the granted length
    a_r9_total_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_ok && !$past(free_valid)) |->
        (total_free == $past(total_free) - TOT_W'(grant_len)));

    // R11: a failed request leaves the total unchanged
    a_r11_fail_keeps_total: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !$past(free_valid)) |-> (total_free == $past(total_free)));

    // R3: a dropped release leaves the total unchanged
    a_r3_no_overflow_change: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !grant_ok) |-> (total_free == $past(total_free)));
endmodule

bind hole_alloc alloc_chk #(
    .NUM_HOLES (NUM_HOLES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MIN_LOG2  (MIN_LOG2),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_size   (req_size),
    .done       (done),
    .grant_ok   (grant_ok),
    .fail       (fail),
    .grant_len  (grant_len),
    .free_valid (free_valid),
    .overflow   (overflow),
    .total_free (total_free)
);

// File: tb/tb_hole_alloc.sv
`timescale 1ns/1ps
module tb_hole_alloc;
    localparam int N  = 8;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int ML = 2;
    localparam int IW = 3;
    localparam int MINV = 1 << ML;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [LW-1:0] req_size = '0;
    logic [1:0] req_policy = 2'b00;
    logic done, grant_ok, fail, overflow;
    logic [AW-1:0] grant_base;
    logic [LW:0] grant_len;
    logic free_valid = 1'b0;
    logic [AW-1:0] free_base = '0;
    logic [LW-1:0] free_len = '0;
    logic [LW+IW:0] total_free;

    always #2 clk = ~clk;

    hole_alloc dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_policy(req_policy), .done(done),
        .grant_ok(grant_ok), .fail(fail), .grant_base(grant_base),
        .grant_len(grant_len), .free_valid(free_valid), .free_base(free_base),
        .free_len(free_len), .overflow(overflow), .total_free(total_free)
    );

    typedef struct {
        bit    ok;
        int    base;
        int    len;
        int    lat;
        int    acc;
        string tag;
    } item_t;

    item_t exp_q[$];
    int n_total = 0, n_bad = 0;
    int sent = 0, got = 0;
    int cyc = 0;
    bit finished = 0;

    int mb[N], ml[N];
    bit mv[N];
    int mtot = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit cond, string req, string what, longint act, longint expv);
        n_total++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    // monitor: compares each completion with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R12", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(grant_ok == it.ok, it.tag, "grant_ok", grant_ok, it.ok);
                chk(fail == !it.ok, "R12", "fail flag", fail, !it.ok);
                if (it.ok) chk(int'(grant_base) == it.base, it.tag, "grant_base", grant_base, it.base);
                chk(int'(grant_len) == it.len, "R4", "grant_len", grant_len, it.len);
                chk(cyc - it.acc == it.lat, "R12", "done latency", cyc - it.acc, it.lat);
            end
            got++;
        end
    end

    function automatic int round_up(int s);
        if (s == 0) return MINV;
        return ((s + MINV - 1) / MINV) * MINV;
    endfunction

    task automatic do_free(int b, int l, string tag);
        bit exp_ovf = 0;
        @(negedge clk);
        free_valid = 1'b1; free_base = AW'(b); free_len = LW'(l);
        if (l != 0) begin
            int slot = -1;
            for (int i = 0; i < N; i++) if (!mv[i] && slot < 0) slot = i;
            if (slot < 0) exp_ovf = 1;
            else begin mv[slot] = 1; mb[slot] = b; ml[slot] = l; mtot += l; end
        end
        @(negedge clk);
        free_valid = 1'b0;
        chk(overflow == exp_ovf, tag, "overflow", overflow, exp_ovf);
        chk(int'(total_free) == mtot, tag, "total_free after release", total_free, mtot);
    endtask

    task automatic do_alloc(int s, int pol, string tag);
        item_t it;
        int need = round_up(s);
        int hit = -1;
        bit ff = (pol == 0) || (pol == 3);
        for (int i = 0; i < N; i++) begin
            if (mv[i] && ml[i] >= need) begin
                if (hit < 0) hit = i;
                else if (!ff && pol == 1 && ml[i] < ml[hit]) hit = i;
                else if (!ff && pol == 2 && ml[i] > ml[hit]) hit = i;
            end
        end
        it.ok  = (hit >= 0);
        it.len = need;
        it.tag = tag;
        it.lat = (ff && hit >= 0) ? hit + 1 : N;
        it.base = (hit >= 0) ? mb[hit] : 0;
        if (hit >= 0) begin
            mb[hit] += need; ml[hit] -= need; mtot -= need;
            if (ml[hit] == 0) mv[hit] = 0;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_size = LW'(s); req_policy = 2'(pol);
        it.acc = cyc + 1;
        exp_q.push_back(it);
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12", "ready low during scan", req_ready, 0);
        wait (got == sent);
        @(negedge clk);
        chk(int'(total_free) == mtot, tag, "total_free after request", total_free, mtot);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin mv[i] = 0; mb[i] = 0; ml[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(done == 1'b0, "R1", "done", done, 0);
        chk(overflow == 1'b0, "R1", "overflow", overflow, 0);
        chk(total_free == '0, "R1", "total_free", total_free, 0);

        // R2: fill five slots, then a zero-length release
        do_free('h100, 20, "R2");
        do_free('h200, 12, "R2");
        do_free('h300, 40, "R2");
        do_free('h400, 12, "R2");
        do_free('h500, 40, "R2");
        do_free('h700, 0,  "R2");

        do_alloc(10, 0, "R5");   // 12 from slot 0 at 0x100
        do_alloc(9,  1, "R6");   // tie 12/12, slot 1 at 0x200, slot emptied
        do_alloc(1,  2, "R8");   // tie 40/40, slot 2 at 0x300
        do_alloc(4,  2, "R7");   // slot 4 is now largest, 0x500
        do_alloc(0,  0, "R9");   // remainder of slot 0 at 0x10C
        do_alloc(37, 1, "R11");  // 40 needed, largest is 36
        do_alloc(5,  3, "R5");   // spare code acts as first-fit, slot 2
        do_free('h600, 16, "R10"); // reuses emptied slot 1
        do_alloc(13, 1, "R10");  // exact 16 in slot 1 at 0x600
        do_alloc(12, 1, "R6");   // exact 12 in slot 3
        do_alloc(28, 2, "R7");   // slot 4 (36) over slot 2 (28)
        do_alloc(7, 0, "R4");    // rounds to 8
        do_free('h800, 8, "R2");
        do_free('h900, 8, "R2");
        do_free('hA00, 8, "R2");
        do_free('hB00, 8, "R2");
        do_free('hC00, 8, "R2");
        do_free('hD00, 8, "R2");
        do_free('hE00, 8, "R3");
        do_free('hF00, 8, "R3");
        do_alloc(8, 2, "R8");
        do_alloc(200, 0, "R11");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R12", "pending completions", exp_q.size(), 0);
        finish_run();
    end
endmodule